// File: doc/BRIEF.md
# Aligned PWM Timer with Synchronized Compare Buffers

This block is a multi-channel pulse-width modulator built around one shared counter. The counter either ramps upward and wraps, which gives edge-aligned waveforms, or ramps up and then back down, which gives waveforms centred on the counter's zero point. Every channel compares the shared count against its own match value. It then passes the result through a per-channel polarity inversion and an output-enable gate.

Software programs the block through a single-cycle write port. The modulo, the match values and the counting mode are written into shadow copies. A one-cycle sync strobe arms a pending flag. The shadow copies move into the working registers on the next tick that ends a PWM period, and the flag then clears by itself. A period already in progress therefore always finishes with the values it started with. Polarity is not buffered and takes effect at once.

A clock-enable input stands in for a prescaled counter clock. The counter only moves on cycles where this input is high.

Top module: `pwm_aligned_timer`

## Requirements
- R1: After reset the counter is 0 and counts upward. The working and shadow modulo, match and mode values are 0, with mode 0 meaning edge-aligned. All polarity bits are 0, no load is pending, and every output is low.
- R2: Writes are decoded by address. Address 0 is control: bit 0 is the buffered mode (0 edge-aligned, 1 center-aligned), and bit i+1 is the polarity of channel i. Address 1 is the modulo. Address 2+i is the match value of channel i. Writes to any other address change nothing.
- R3: In edge-aligned mode, each enabled tick advances the counter by one. When the counter has reached the modulo, the next tick returns it to 0. The period is therefore modulo+1 ticks.
- R4: In center-aligned mode with modulo M ≥ 2, the counter runs 0, 1, …, M, M−1, …, 1 and then starts again at 0, giving a period of 2·M ticks. With M = 1 it alternates 0 and 1. With M = 0 it stays at 0.
- R5: In edge-aligned mode the raw channel level is active while the counter is below the match value. It asserts when the counter is 0 and deasserts when the counter equals the match value.
- R6: In center-aligned mode the raw level is also active while the counter is below the match value. It deasserts on the up-count match and reasserts when the down-count falls below the match. For 1 ≤ match ≤ M this gives 2·match−1 active ticks per period.
- R7: A match value of 0 gives a level that never becomes active (0% duty). A match value greater than the modulo gives a level that is active for the whole period (100% duty).
- R8: Writes to the shadow copies have no effect on the waveform until a sync strobe. The strobe arms a pending load. The load is applied on the first tick that ends a period and then clears by itself, so later period ends reload nothing without a new strobe.
- R9: Polarity bit 0 drives the raw level straight out: idle low, high for the duty portion. Polarity bit 1 inverts it. Polarity changes apply on the cycle after the write.
- R10: When a channel's output-enable bit is low, its output is held at its inactive level, which equals its polarity bit, whatever the counter does.
- R11: While the clock-enable input is low, the counter, the pending flag's release and all outputs stay frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Counter clock enable (prescaled tick) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address |
| wr_data_i | input | CNT_W | Register write data |
| sync_i | input | 1 | Software sync strobe, arms buffered load |
| out_en_i | input | NUM_CH | Per-channel output enable |
| pwm_o | output | NUM_CH | PWM outputs |

## Verification
Suppose the counter, its direction or the pending flag goes wrong. The result shows at the ports within one tick: an output edge moves to the wrong counter value, or a buffered value lands in the middle of a period instead of at its end. To catch this, the bench runs a behavioural model of counter and buffers alongside the block and compares every output on every cycle. It also counts active cycles per period under edge and center counting, at 0% and 100% duty, with inverted polarity, and with a disabled channel. A load that comes early or is missed therefore shows up as a duty-count mismatch inside the first period after the strobe.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {
    MODE_EDGE   = 1'b0,
    MODE_CENTER = 1'b1
  } cnt_mode_e;

  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_MOD    = 1;
  localparam int ADDR_MATCH0 = 2;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  cnt_mode_e        mode_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             down_q, down_d;
  logic             at_end;

  always_comb begin
    at_end = 1'b0;
    cnt_d  = cnt_q;
    down_d = down_q;
    if (mode_i == MODE_EDGE) begin
      down_d = 1'b0;
      if (cnt_q >= mod_i) begin
        at_end = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else if (!down_q) begin
      if (cnt_q >= mod_i) begin
        if (mod_i <= ONE) begin
          // degenerate period: restart without a down phase
          at_end = 1'b1;
          cnt_d  = '0;
        end else begin
          cnt_d  = mod_i - ONE;
          down_d = 1'b1;
        end
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else begin
      if (cnt_q <= ONE) begin
        at_end = 1'b1;
        cnt_d  = '0;
        down_d = 1'b0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (tick_en_i) begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_en_i & at_end;
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [CNT_W-1:0]              wr_data_i,
  input  logic                          sync_i,
  input  logic                          wrap_i,
  output cnt_mode_e                     mode_o,
  output logic [CNT_W-1:0]              mod_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  match_o,
  output logic [NUM_CH-1:0]             pol_o,
  output logic                          pending_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_MOD  = ADDR_W'(ADDR_MOD);

  logic             pend_q;
  logic             load;
  logic             sel_ctrl, sel_mod;
  cnt_mode_e        mode_sh_q, mode_q;
  logic [CNT_W-1:0] mod_sh_q, mod_q;
  logic [NUM_CH-1:0] pol_q;

  assign load     = wrap_i & pend_q;
  assign sel_ctrl = wr_en_i && (wr_addr_i == A_CTRL);
  assign sel_mod  = wr_en_i && (wr_addr_i == A_MOD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else if (sync_i) begin
      pend_q <= 1'b1;
    end else if (load) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_sh_q <= MODE_EDGE;
      pol_q     <= '0;
    end else if (sel_ctrl) begin
      mode_sh_q <= cnt_mode_e'(wr_data_i[0]);
      pol_q     <= wr_data_i[NUM_CH:1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_sh_q <= '0;
    end else if (sel_mod) begin
      mod_sh_q <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_EDGE;
      mod_q  <= '0;
    end else if (load) begin
      mode_q <= mode_sh_q;
      mod_q  <= mod_sh_q;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_match
    localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'(ADDR_MATCH0 + i);
    logic [CNT_W-1:0] sh_q, act_q;
    logic             sel;
    assign sel = wr_en_i && (wr_addr_i == A_MATCH);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q <= '0;
      end else if (sel) begin
        sh_q <= wr_data_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q <= '0;
      end else if (load) begin
        act_q <= sh_q;
      end
    end

    assign match_o[i] = act_q;
  end

  assign mode_o    = mode_q;
  assign mod_o     = mod_q;
  assign pol_o     = pol_q;
  assign pending_o = pend_q;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] match_i,
  input  logic             pol_i,
  input  logic             en_i,
  output logic             pwm_o
);
  logic raw;

  // below-match window covers 0% (match 0) and 100% (match > modulo)
  assign raw   = cnt_i < match_i;
  assign pwm_o = en_i ? (raw ^ pol_i) : pol_i;
endmodule

// File: rtl/pwm_aligned_timer.sv
module pwm_aligned_timer
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = $clog2(NUM_CH + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              sync_i,
  input  logic [NUM_CH-1:0] out_en_i,
  output logic [NUM_CH-1:0] pwm_o
);
  cnt_mode_e                    mode_q;
  logic [CNT_W-1:0]             mod_q;
  logic [CNT_W-1:0]             cnt_q;
  logic                         wrap;
  logic                         pending;
  logic [NUM_CH-1:0][CNT_W-1:0] match_q;
  logic [NUM_CH-1:0]            pol_q;

  pwm_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_en_i (tick_en_i),
    .mode_i    (mode_q),
    .mod_i     (mod_q),
    .cnt_o     (cnt_q),
    .wrap_o    (wrap)
  );

  pwm_shadow_regs #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .sync_i    (sync_i),
    .wrap_i    (wrap),
    .mode_o    (mode_q),
    .mod_o     (mod_q),
    .match_o   (match_q),
    .pol_o     (pol_q),
    .pending_o (pending)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .cnt_i   (cnt_q),
      .match_i (match_q[i]),
      .pol_i   (pol_q[i]),
      .en_i    (out_en_i[i]),
      .pwm_o   (pwm_o[i])
    );
  end
endmodule

// File: rtl/pwm_aligned_timer_chk.sv
module pwm_aligned_timer_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         tick_en_i,
  input logic                         sync_i,
  input logic [NUM_CH-1:0]            out_en_i,
  input logic [NUM_CH-1:0]            pwm_i,
  input logic [CNT_W-1:0]             cnt_i,
  input logic [CNT_W-1:0]             mod_i,
  input logic [NUM_CH-1:0][CNT_W-1:0] match_i,
  input logic [NUM_CH-1:0]            pol_i,
  input logic                         wrap_i,
  input logic                         pending_i
);
  assert_cnt_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= mod_i);

  assert_hold_when_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_en_i |=> $stable(cnt_i));

  assert_load_only_on_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> ($stable(mod_i) && $stable(match_i)));

  assert_pending_self_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_i && wrap_i && !sync_i) |=> !pending_i);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    assert_safe_level_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !out_en_i[i] |-> (pwm_i[i] == pol_i[i]));

    assert_zero_duty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_en_i[i] && match_i[i] == '0) |-> (pwm_i[i] == pol_i[i]));
  end
endmodule

bind pwm_aligned_timer pwm_aligned_timer_chk #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_en_i (tick_en_i),
  .sync_i    (sync_i),
  .out_en_i  (out_en_i),
  .pwm_i     (pwm_o),
  .cnt_i     (cnt_q),
  .mod_i     (mod_q),
  .match_i   (match_q),
  .pol_i     (pol_q),
  .wrap_i    (wrap),
  .pending_i (pending)
);

// File: tb/pwm_aligned_timer_tb.sv
module pwm_aligned_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 4;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = $clog2(NUM_CH + 2);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick_en = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [CNT_W-1:0]  wr_data = '0;
  logic              sync = 1'b0;
  logic [NUM_CH-1:0] out_en = '0;
  logic [NUM_CH-1:0] pwm;

  int    n_vec = 0;
  int    n_err = 0;
  string cur_req = "R1";

  // reference model state
  int m_cnt, m_mod, s_mod;
  bit m_down, m_mode, s_mode, m_pend;
  int m_match [NUM_CH];
  int s_match [NUM_CH];
  bit m_pol   [NUM_CH];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_aligned_timer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_en_i (tick_en),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .sync_i    (sync),
    .out_en_i  (out_en),
    .pwm_o     (pwm)
  );

  always @(posedge clk or negedge rst_n) begin
    int nc;
    bit nd, wrap;
    if (!rst_n) begin
      m_cnt = 0; m_down = 0; m_mode = 0; s_mode = 0; m_mod = 0; s_mod = 0; m_pend = 0;
      for (int i = 0; i < NUM_CH; i++) begin
        m_match[i] = 0; s_match[i] = 0; m_pol[i] = 0;
      end
    end else begin
      nc = m_cnt; nd = m_down; wrap = 0;
      if (tick_en) begin
        if (!m_mode) begin
          if (m_cnt >= m_mod) begin nc = 0; wrap = 1; end
          else nc = m_cnt + 1;
        end else if (!m_down) begin
          if (m_cnt >= m_mod) begin
            if (m_mod <= 1) begin nc = 0; wrap = 1; end
            else begin nc = m_mod - 1; nd = 1; end
          end else nc = m_cnt + 1;
        end else begin
          if (m_cnt <= 1) begin nc = 0; nd = 0; wrap = 1; end
          else nc = m_cnt - 1;
        end
      end
      if (wrap && m_pend) begin
        m_mode = s_mode; m_mod = s_mod;
        for (int i = 0; i < NUM_CH; i++) m_match[i] = s_match[i];
      end
      if (sync) m_pend = 1;
      else if (wrap) m_pend = 0;
      if (wr_en) begin
        if (wr_addr == 0) begin
          s_mode = wr_data[0];
          for (int i = 0; i < NUM_CH; i++) m_pol[i] = wr_data[i+1];
        end else if (wr_addr == 1) begin
          s_mod = int'(wr_data);
        end else if (int'(wr_addr) >= 2 && int'(wr_addr) < 2 + NUM_CH) begin
          s_match[int'(wr_addr) - 2] = int'(wr_data);
        end
      end
      m_cnt = nc; m_down = nd;
    end
  end

  function automatic logic [NUM_CH-1:0] model_out();
    logic [NUM_CH-1:0] r;
    for (int i = 0; i < NUM_CH; i++)
      r[i] = out_en[i] ? ((m_cnt < m_match[i]) ^ m_pol[i]) : m_pol[i];
    return r;
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    logic [NUM_CH-1:0] exp_o;
    #1;
    exp_o = model_out();
    n_vec++;
    if (pwm !== exp_o) begin
      n_err++;
      $display("FAIL %s: pwm_o=%b expected %b (t=%0t)", cur_req, pwm, exp_o, $time);
    end
  end

  task automatic check_val(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(int addr, int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = CNT_W'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_sync();
    @(negedge clk);
    sync = 1'b1;
    @(negedge clk);
    sync = 1'b0;
  endtask

  task automatic count_high(int n, output int cnt [NUM_CH]);
    for (int i = 0; i < NUM_CH; i++) cnt[i] = 0;
    repeat (n) begin
      @(negedge clk);
      #2;
      for (int i = 0; i < NUM_CH; i++) if (pwm[i]) cnt[i]++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    int c [NUM_CH];
    logic [NUM_CH-1:0] snap;

    repeat (3) @(negedge clk);
    #2;
    check_val("R1 reset outputs", int'(pwm), 0);
    rst_n = 1'b1;
    out_en = '1;
    tick_en = 1'b1;
    @(negedge clk);
    #2;
    check_val("R1 outputs after reset", int'(pwm), 0);

    // edge-aligned, period 10
    cur_req = "R3/R5";
    do_write(0, 0);
    do_write(1, 9);
    do_write(2, 3);
    do_write(3, 0);
    do_write(4, 12);
    do_write(5, 9);
    do_sync();
    repeat (3) @(negedge clk);
    count_high(10, c);
    check_val("R5 edge duty match 3", c[0], 3);
    check_val("R7 zero duty", c[1], 0);
    check_val("R7 full duty match>mod", c[2], 10);
    check_val("R3 match=mod over period mod+1", c[3], 9);

    // shadow writes without sync must not matter
    cur_req = "R8";
    do_write(1, 4);
    do_write(2, 1);
    count_high(10, c);
    check_val("R8 no load without sync", c[0], 3);
    do_sync();
    repeat (12) @(negedge clk);
    count_high(5, c);
    check_val("R8 loaded match ch0", c[0], 1);
    check_val("R8 loaded mod ch3", c[3], 5);

    // center-aligned, period 10
    cur_req = "R4/R6";
    do_write(0, 1);
    do_write(1, 5);
    do_write(2, 2);
    do_write(3, 0);
    do_write(4, 6);
    do_write(5, 5);
    do_sync();
    repeat (12) @(negedge clk);
    count_high(10, c);
    check_val("R6 center duty match 2", c[0], 3);
    check_val("R7 center zero duty", c[1], 0);
    check_val("R7 center full duty", c[2], 10);
    check_val("R6 center match=mod", c[3], 9);

    // polarity inversion on ch0, immediate
    cur_req = "R9";
    do_write(0, 1 | (1 << 1));
    count_high(10, c);
    check_val("R9 inverted ch0", c[0], 7);

    // disabled channel held at inactive level
    cur_req = "R10";
    out_en = 4'b1110;
    count_high(10, c);
    check_val("R10 disabled ch0 at polarity level 1", c[0], 10);
    do_write(0, 1);
    count_high(10, c);
    check_val("R10 disabled ch0 at polarity level 0", c[0], 0);
    out_en = '1;

    // unmapped address ignored
    cur_req = "R2";
    do_write(7, 16'hffff);
    do_sync();
    repeat (12) @(negedge clk);
    count_high(10, c);
    check_val("R2 unmapped write ignored ch0", c[0], 3);
    check_val("R2 unmapped write ignored ch1", c[1], 0);

    // freeze
    cur_req = "R11";
    @(negedge clk);
    tick_en = 1'b0;
    #2;
    snap = pwm;
    repeat (8) begin
      @(negedge clk);
      #2;
      check_val("R11 output frozen", int'(pwm), int'(snap));
    end
    tick_en = 1'b1;

    // center with modulo 1
    cur_req = "R4";
    do_write(1, 1);
    do_write(2, 1);
    do_sync();
    repeat (12) @(negedge clk);
    count_high(10, c);
    check_val("R4 center mod 1 alternates", c[0], 5);

    repeat (5) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule